// File: doc/BRIEF.md
# Contact Monitor Serial Status/Command Port

This block is the serial slave port of a switch contact monitor. A host pulls chip select low, clocks a 16-bit frame, and in that frame reads a status word while it writes a command word. The status word is captured once, at the moment chip select goes low. Its upper byte holds the eight switch levels and the bit below them holds an overtemperature warning. The command word becomes the configuration register only when chip select returns high after a frame of exactly the right length.

The block also holds an interrupt. The interrupt is raised when any switch differs from the switch levels captured at the start of the last access. It stays raised until the next access begins, and a switch change during an access raises it as usual. The overtemperature warning is sticky in the same way, so a short overheat between two reads is still reported.

All serial pins are oversampled in the system clock domain through a synchronizer of configurable depth. Serial clock and data are acted on only while chip select is low. The serial data output and the interrupt are modelled as output enables, so the pad ring can build a tri-state driver and an open-drain, active-low pull-down from them.

Top module: `cmon_spi_slave`

## Requirements
- R1: A frame transfers 16 bits in each direction, most significant bit first, on both the serial output and the serial input.
- R2: The status word is captured when chip select falls. Switch k is placed at bit 8+k (1 = closed, 0 = open), the overtemperature warning is at bit 7, and bits 6 to 0 read as 0.
- R3: The status MSB is on the serial output before the first serial clock edge. The output moves to the next bit on each rising serial clock edge and changes at no other time during a frame. Serial input is sampled on each falling serial clock edge.
- R4: When chip select rises after exactly 16 falling serial clock edges, the received word is written to the command register. After any other count, the command register keeps its value.
- R5: While chip select is high, the serial output enable is 0 and serial clock and data activity changes no state visible at the ports.
- R6: The interrupt enable rises when any switch level differs from the reference captured at the last chip-select fall. It then holds until the next chip-select fall, and this applies also to changes made while chip select is low.
- R7: A chip-select fall clears the interrupt enable and loads the current switch levels as the new reference.
- R8: The overtemperature warning is sticky: any high level on the overtemperature input sets it. A chip-select fall clears it after it has been captured into the status word.
- R9: After reset, the command register is all zeros, the serial output enable and the interrupt enable are 0, and the switch reference reads as all open.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock used to oversample the serial pins |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Serial data from the host |
| sw_i | input | SW_W | Debounced switch levels, 1 = closed |
| ot_i | input | 1 | Overtemperature level |
| sdo_o | output | 1 | Serial data to the host |
| sdo_oe_o | output | 1 | Output enable for the serial data driver |
| irq_oe_o | output | 1 | Pull-down enable for the open-drain interrupt pin |
| cmd_o | output | FRAME_W | Command register |

## Verification
The bench builds the block with its defaults: a 16-bit frame, eight switches and a two-stage synchronizer. It holds each serial clock phase for eight system clocks, so every pin change has passed the synchronizer and edge detector before it is sampled. With these values the full status layout can be reached, and frames of 15, 16 and 17 clocks test the exact-count commit rule. Sticky overtemperature pulses, switch changes during a frame and serial clock activity with chip select high are also exercised.

// File: rtl/cmon_spi_pkg.sv
package cmon_spi_pkg;

  typedef struct packed {
    logic cs_n;
    logic sck;
    logic sdi;
  } spi_pins_t;

  typedef struct packed {
    logic cs_fall;
    logic cs_rise;
    logic sck_rise;
    logic sck_fall;
  } spi_evt_t;

  localparam spi_pins_t PinsIdle = '{cs_n: 1'b1, sck: 1'b0, sdi: 1'b0};

endpackage

// File: rtl/cmon_sync.sv
module cmon_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= {STAGES{RST_VAL}};
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/cmon_spi_edge.sv
module cmon_spi_edge
  import cmon_spi_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  spi_pins_t pins_i,
  output spi_evt_t  evt_o
);

  spi_pins_t prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= PinsIdle;
    else         prev_q <= pins_i;
  end

  // serial clock edges count only inside a frame, never on the select edges
  logic in_frame;
  assign in_frame = !prev_q.cs_n && !pins_i.cs_n;

  assign evt_o.cs_fall  = prev_q.cs_n && !pins_i.cs_n;
  assign evt_o.cs_rise  = !prev_q.cs_n && pins_i.cs_n;
  assign evt_o.sck_rise = in_frame && !prev_q.sck && pins_i.sck;
  assign evt_o.sck_fall = in_frame && prev_q.sck && !pins_i.sck;

endmodule

// File: rtl/cmon_status.sv
module cmon_status #(
  parameter int unsigned SW_W    = 8,
  parameter int unsigned FRAME_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [SW_W-1:0]    sw_i,
  input  logic               ot_i,
  input  logic               cs_fall_i,
  output logic [FRAME_W-1:0] status_o,
  output logic               irq_o
);

  localparam int unsigned PadW = FRAME_W - SW_W - 1;

  logic [SW_W-1:0] ref_q;
  logic            irq_q;
  logic            ot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q <= '0;
      irq_q <= 1'b0;
      ot_q  <= 1'b0;
    end else if (cs_fall_i) begin
      ref_q <= sw_i;
      irq_q <= 1'b0;
      ot_q  <= 1'b0;
    end else begin
      irq_q <= irq_q | (sw_i != ref_q);
      ot_q  <= ot_q | ot_i;
    end
  end

  generate
    if (PadW > 0) begin : g_pad
      assign status_o = {sw_i, ot_q | ot_i, {PadW{1'b0}}};
    end else begin : g_nopad
      assign status_o = {sw_i, ot_q | ot_i};
    end
  endgenerate

  assign irq_o = irq_q;

endmodule

// File: rtl/cmon_spi_shifter.sv
module cmon_spi_shifter
  import cmon_spi_pkg::*;
#(
  parameter int unsigned FRAME_W = 16,
  parameter int unsigned CNT_W   = $clog2(FRAME_W + 2)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  spi_evt_t           evt_i,
  input  logic               sdi_i,
  input  logic [FRAME_W-1:0] status_i,
  output logic               sdo_o,
  output logic               sdo_oe_o,
  output logic [FRAME_W-1:0] cmd_o,
  output logic [CNT_W-1:0]   bit_cnt_o
);

  localparam logic [CNT_W-1:0] CntFull = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CntSat  = CNT_W'(FRAME_W + 1);

  logic [FRAME_W-1:0] sh_q;
  logic [FRAME_W-1:0] cmd_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               sdo_q;
  logic               oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cmd_q <= '0;
      cnt_q <= '0;
      sdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else if (evt_i.cs_fall) begin
      sh_q  <= status_i;
      cnt_q <= '0;
      sdo_q <= status_i[FRAME_W-1];
      oe_q  <= 1'b1;
    end else begin
      if (evt_i.cs_rise) begin
        oe_q <= 1'b0;
        if (cnt_q == CntFull) cmd_q <= sh_q;
      end
      if (evt_i.sck_fall) begin
        sh_q <= {sh_q[FRAME_W-2:0], sdi_i};
        // saturate so an overlong frame never wraps back to a valid count
        if (cnt_q != CntSat) cnt_q <= cnt_q + 1'b1;
      end
      if (evt_i.sck_rise) sdo_q <= sh_q[FRAME_W-1];
    end
  end

  assign sdo_o     = sdo_q;
  assign sdo_oe_o  = oe_q;
  assign cmd_o     = cmd_q;
  assign bit_cnt_o = cnt_q;

endmodule

// File: rtl/cmon_spi_slave.sv
module cmon_spi_slave
  import cmon_spi_pkg::*;
#(
  parameter int unsigned FRAME_W     = 16,
  parameter int unsigned SW_W        = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_ni,
  input  logic               sck_i,
  input  logic               sdi_i,
  input  logic [SW_W-1:0]    sw_i,
  input  logic               ot_i,
  output logic               sdo_o,
  output logic               sdo_oe_o,
  output logic               irq_oe_o,
  output logic [FRAME_W-1:0] cmd_o
);

  localparam int unsigned CNT_W = $clog2(FRAME_W + 2);
  localparam int unsigned MON_W = SW_W + 1;

  spi_pins_t         pins_raw, pins_s;
  spi_evt_t          evt;
  logic [MON_W-1:0]  mon_s;
  logic [FRAME_W-1:0] status_w;
  logic [CNT_W-1:0]  bit_cnt;
  logic              cs_fall_w, cs_rise_w, sck_rise_w;

  assign pins_raw = '{cs_n: cs_ni, sck: sck_i, sdi: sdi_i};

  cmon_sync #(
    .W      ($bits(spi_pins_t)),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PinsIdle)
  ) i_pin_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_raw),
    .q_o   (pins_s)
  );

  cmon_sync #(
    .W      (MON_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL('0)
  ) i_mon_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sw_i, ot_i}),
    .q_o   (mon_s)
  );

  cmon_spi_edge i_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pins_i(pins_s),
    .evt_o (evt)
  );

  cmon_status #(
    .SW_W   (SW_W),
    .FRAME_W(FRAME_W)
  ) i_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sw_i     (mon_s[MON_W-1:1]),
    .ot_i     (mon_s[0]),
    .cs_fall_i(evt.cs_fall),
    .status_o (status_w),
    .irq_o    (irq_oe_o)
  );

  cmon_spi_shifter #(
    .FRAME_W(FRAME_W),
    .CNT_W  (CNT_W)
  ) i_shifter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (evt),
    .sdi_i    (pins_s.sdi),
    .status_i (status_w),
    .sdo_o    (sdo_o),
    .sdo_oe_o (sdo_oe_o),
    .cmd_o    (cmd_o),
    .bit_cnt_o(bit_cnt)
  );

  assign cs_fall_w  = evt.cs_fall;
  assign cs_rise_w  = evt.cs_rise;
  assign sck_rise_w = evt.sck_rise;

endmodule

// File: rtl/cmon_spi_chk.sv
module cmon_spi_chk #(
  parameter int unsigned FRAME_W = 16,
  parameter int unsigned CNT_W   = 5
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cs_fall,
  input logic               cs_rise,
  input logic               sck_rise,
  input logic [CNT_W-1:0]   bit_cnt,
  input logic [FRAME_W-1:0] cmd_o,
  input logic               sdo_o,
  input logic               sdo_oe_o,
  input logic               irq_oe_o
);

  // R4
  cmd_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cmd_o) |-> $past(cs_rise && (bit_cnt == CNT_W'(FRAME_W))));

  // R4
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt <= CNT_W'(FRAME_W + 1));

  // R7
  irq_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_fall |=> !irq_oe_o);

  // R6
  irq_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_oe_o && !cs_fall) |=> irq_oe_o);

  // R5
  oe_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sdo_oe_o) |-> $past(cs_fall));

  // R5
  oe_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sdo_oe_o) |-> $past(cs_rise));

  // R3
  sdo_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sck_rise && !cs_fall) |=> $stable(sdo_o));

endmodule

bind cmon_spi_slave cmon_spi_chk #(
  .FRAME_W(FRAME_W),
  .CNT_W  (CNT_W)
) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cs_fall (cs_fall_w),
  .cs_rise (cs_rise_w),
  .sck_rise(sck_rise_w),
  .bit_cnt (bit_cnt),
  .cmd_o   (cmd_o),
  .sdo_o   (sdo_o),
  .sdo_oe_o(sdo_oe_o),
  .irq_oe_o(irq_oe_o)
);

// File: tb/test_cmon_spi_slave.sv
`timescale 1ns/1ps
module test_cmon_spi_slave;

  localparam int H = 8;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cs_ni = 1'b1;
  logic        sck_i = 1'b0;
  logic        sdi_i = 1'b0;
  logic [7:0]  sw_i = 8'h00;
  logic        ot_i = 1'b0;
  logic        sdo_o, sdo_oe_o, irq_oe_o;
  logic [15:0] cmd_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [7:0]  ref_m = 8'h00;
  logic        irq_m = 1'b0;
  logic        ot_m  = 1'b0;
  logic [15:0] cmd_m = 16'h0000;

  always #2 clk = ~clk;

  cmon_spi_slave i_cmon_spi_slave (
    .clk_i   (clk),
    .rst_ni  (rst_ni),
    .cs_ni   (cs_ni),
    .sck_i   (sck_i),
    .sdi_i   (sdi_i),
    .sw_i    (sw_i),
    .ot_i    (ot_i),
    .sdo_o   (sdo_o),
    .sdo_oe_o(sdo_oe_o),
    .irq_oe_o(irq_oe_o),
    .cmd_o   (cmd_o)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_status(input logic [7:0] sw, input logic ot);
    return {sw, ot, 7'b0};
  endfunction

  task automatic set_sw(input logic [7:0] v);
    sw_i = v;
    if (v != ref_m) irq_m = 1'b1;
    wait_clk(H);
  endtask

  task automatic pulse_ot();
    ot_i = 1'b1;
    ot_m = 1'b1;
    wait_clk(2);
    ot_i = 1'b0;
    wait_clk(H);
  endtask

  // mid_at < 0 means no switch change during the frame
  task automatic frame(input logic [15:0] wr, input int nclk, input int mid_at,
                       input logic [7:0] mid_sw);
    logic [15:0] st;
    logic [15:0] rd;
    st = exp_status(sw_i, ot_m | ot_i);
    ref_m = sw_i;
    irq_m = 1'b0;
    ot_m = ot_i;
    rd = '0;
    cs_ni = 1'b0;
    wait_clk(H);
    check("R5 oe in frame", {31'b0, sdo_oe_o}, 32'd1);
    check("R7 irq cleared", {31'b0, irq_oe_o}, 32'd0);
    check("R3 first bit", {31'b0, sdo_o}, {31'b0, st[15]});
    for (int i = 0; i < nclk; i++) begin
      sck_i = 1'b1;
      sdi_i = (i < 16) ? wr[15-i] : 1'b0;
      wait_clk(H);
      if (i < 16) rd[15-i] = sdo_o;
      if (i == mid_at) begin
        sw_i = mid_sw;
        if (mid_sw != ref_m) irq_m = 1'b1;
      end
      sck_i = 1'b0;
      wait_clk(H);
    end
    cs_ni = 1'b1;
    wait_clk(H);
    if (nclk >= 16) check("R1 R2 status read", {16'b0, rd}, {16'b0, st});
    if (nclk == 16) cmd_m = wr;
    check("R4 command", {16'b0, cmd_o}, {16'b0, cmd_m});
    check("R6 irq after frame", {31'b0, irq_oe_o}, {31'b0, irq_m});
    check("R5 oe idle", {31'b0, sdo_oe_o}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    wait_clk(4);
    // R9 reset state
    check("R9 cmd reset", {16'b0, cmd_o}, 32'd0);
    check("R9 oe reset", {31'b0, sdo_oe_o}, 32'd0);
    check("R9 irq reset", {31'b0, irq_oe_o}, 32'd0);
    rst_ni = 1'b1;
    wait_clk(H);
    check("R9 irq after release", {31'b0, irq_oe_o}, 32'd0);

    frame(16'hA5C3, 16, -1, 8'h00);

    // R6 change while idle; R2 R8 sticky warning
    set_sw(8'h81);
    check("R6 irq idle change", {31'b0, irq_oe_o}, 32'd1);
    pulse_ot();
    frame(16'h1234, 16, -1, 8'h00);
    frame(16'h5678, 16, -1, 8'h00);

    // R4 wrong lengths
    frame(16'hFFFF, 15, -1, 8'h00);
    frame(16'h0F0F, 17, -1, 8'h00);
    frame(16'h0000, 0, -1, 8'h00);

    // R5 serial activity with select high
    for (int i = 0; i < 20; i++) begin
      sck_i = ~sck_i;
      sdi_i = 1'($urandom);
      wait_clk(H);
    end
    sck_i = 1'b0;
    wait_clk(H);
    check("R5 cmd ignored", {16'b0, cmd_o}, {16'b0, cmd_m});
    check("R5 oe off", {31'b0, sdo_oe_o}, 32'd0);
    frame(16'hC001, 16, -1, 8'h00);

    // R6 change during frame, then back: stays set
    frame(16'h7E7E, 16, 5, 8'h3C);
    set_sw(8'h81);
    check("R6 sticky", {31'b0, irq_oe_o}, 32'd1);

    for (int k = 0; k < 40; k++) begin
      int sel;
      logic [7:0] nsw;
      nsw = 8'($urandom);
      if ($urandom % 3 != 0) set_sw(nsw);
      if ($urandom % 4 == 0) pulse_ot();
      sel = int'($urandom % 5);
      frame(16'($urandom), (sel == 0) ? 15 : (sel == 1) ? 17 : 16,
            ($urandom % 4 == 0) ? int'($urandom % 16) : -1, 8'($urandom));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule